// File: doc/BRIEF.md
# Floating-Point Status and Control Register

This block holds the status and control word that sits beside a floating-point unit. The word has three fields. A rounding-mode field is written by software and decoded for the datapath. A cause field records the exceptions raised by the operation now in flight. A flag field gathers every exception raised since software last cleared it. The unit marks the start of each operation with a one-cycle pulse and reports exceptions as a one-hot-per-class vector. Software reads the whole word combinationally and writes it in a single cycle through a plain write strobe.

The exported rounding mode is always a legal one. If software stores a reserved encoding, a status output reports it and the datapath is given round-to-nearest. The bits above the three fields are reserved. They read as zero, and writes to them have no effect.

Top module: `fpsc_reg`

## Requirements
- R1: After reset, `rd_data` reads all zero, `rm_out` is 00 and `rm_reserved` is 0.
- R2: A cycle with `op_start` high and `wr_en` low leaves the cause field equal to exactly that cycle's `exc_vec`. Older cause bits are dropped and the bits reported in the same cycle are kept.
- R3: A cycle with `wr_en` and `op_start` both low ORs `exc_vec` into the cause field and into the flag field.
- R4: The flag field is sticky. Without a write, no flag bit ever returns to 0, and this holds across `op_start` pulses.
- R5: The rounding-mode field is `rd_data[1:0]` and is loaded from `wr_data[1:0]`. Value 00 means round to nearest and 01 means round toward zero, and `rm_out` follows the stored value for these two codes.
- R6: Bits 12 to 31 of `rd_data` always read 0, including the reserved range 22 to 31. Writes to these bits are ignored.
- R7: When the stored mode is 10 or 11, `rm_reserved` is 1 and `rm_out` is 00. The field still reads back the written value.
- R8: On a write, the cause field (`rd_data[6:2]`) and the flag field (`rd_data[11:7]`) load the matching bits of `wr_data`, and so does the mode field. The write takes priority over `op_start` and `exc_vec` in the same cycle. Exception bit order is: bit 0 inexact, bit 1 underflow, bit 2 overflow, bit 3 divide-by-zero, bit 4 invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_start | input | 1 | One-cycle pulse marking the start of an FP operation |
| exc_vec | input | 5 | Exceptions reported this cycle, one bit per class |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 32 | Software write value |
| rd_data | output | 32 | Current register word |
| rm_out | output | 2 | Legal rounding mode given to the datapath |
| rm_reserved | output | 1 | Stored rounding mode uses a reserved code |

## Verification
The two events that can fall in the same cycle are a software write and an update driven by the unit: an `op_start` pulse, an exception report, or both. Directed cycles raise `wr_en` together with `op_start` and a non-zero `exc_vec`, and further cycles raise `op_start` together with `exc_vec` and no write. Randomized traffic then makes every combination of the three strobes appear often. A behavioural model applies the priority write, then op-start replacement, then OR, and the bench compares every field against that model on every clock.

// File: rtl/fpsc_pkg.sv
package fpsc_pkg;

   typedef enum logic [1:0] {
      RM_NEAREST = 2'b00,
      RM_ZERO    = 2'b01,
      RM_RSV_A   = 2'b10,
      RM_RSV_B   = 2'b11
   } fpsc_rm_e;

   // only the two lowest codes select a real rounding behaviour
   function automatic logic rm_is_legal(input logic [1:0] code);
      return (code == RM_NEAREST) || (code == RM_ZERO);
   endfunction

endpackage

// File: rtl/fpsc_exc_bank.sv
// One bank of exception bits. STICKY picks the flag variant, which
// accumulates. Otherwise the bank is the cause variant, which op_start refills.
module fpsc_exc_bank #(
   parameter int W      = 5,
   parameter bit STICKY = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic [W-1:0] set_vec,
   input  logic         wr_en,
   input  logic [W-1:0] wr_val,
   output logic [W-1:0] q
);

   generate
      if (W < 1) begin : g_bad_w
         $error("fpsc_exc_bank: W must be at least 1");
      end
   endgenerate

   genvar i;
   generate
      for (i = 0; i < W; i++) begin : g_bit
         if (STICKY) begin : g_flag
            logic clr_unused;
            assign clr_unused = clr;
            always_ff @(posedge clk) begin
               if (!rst_n)          q[i] <= 1'b0;
               else if (wr_en)      q[i] <= wr_val[i];
               else if (set_vec[i]) q[i] <= 1'b1;
            end
         end else begin : g_cause
            always_ff @(posedge clk) begin
               if (!rst_n)          q[i] <= 1'b0;
               else if (wr_en)      q[i] <= wr_val[i];
               else if (clr)        q[i] <= set_vec[i];
               else if (set_vec[i]) q[i] <= 1'b1;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/fpsc_rm_unit.sv
module fpsc_rm_unit
   import fpsc_pkg::*;
#(
   parameter int RM_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [RM_W-1:0] wr_val,
   output logic [RM_W-1:0] rm_raw,
   output logic [RM_W-1:0] rm_out,
   output logic            rm_reserved
);

   generate
      if (RM_W != 2) begin : g_bad_rm
         $error("fpsc_rm_unit: RM_W must be 2");
      end
   endgenerate

   logic [RM_W-1:0] rm_q;

   always_ff @(posedge clk) begin
      if (!rst_n)     rm_q <= RM_NEAREST;
      else if (wr_en) rm_q <= wr_val;
   end

   always_comb begin
      rm_raw      = rm_q;
      rm_reserved = !rm_is_legal(rm_q);
      rm_out      = rm_reserved ? RM_NEAREST : rm_q;
   end

endmodule

// File: rtl/fpsc_reg.sv
module fpsc_reg
   import fpsc_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int EXC_W   = 5,
   parameter int RM_W    = 2,
   parameter int RSV_LSB = 22
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_start,
   input  logic [EXC_W-1:0]  exc_vec,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic [RM_W-1:0]   rm_out,
   output logic              rm_reserved
);

   localparam int CAUSE_LSB = RM_W;
   localparam int FLAG_LSB  = CAUSE_LSB + EXC_W;
   localparam int USED_W    = FLAG_LSB + EXC_W;

   generate
      if (USED_W > RSV_LSB) begin : g_bad_fit
         $error("fpsc_reg: fields overlap the reserved range");
      end
      if (RSV_LSB > DATA_W) begin : g_bad_rsv
         $error("fpsc_reg: reserved start beyond word width");
      end
   endgenerate

   logic [RM_W-1:0]  rm_raw;
   logic [EXC_W-1:0] cause_q;
   logic [EXC_W-1:0] flag_q;
   logic             unused_wr_hi;

   assign unused_wr_hi = ^wr_data[DATA_W-1:USED_W];

   fpsc_rm_unit #(.RM_W(RM_W)) u_rm (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_val      (wr_data[RM_W-1:0]),
      .rm_raw      (rm_raw),
      .rm_out      (rm_out),
      .rm_reserved (rm_reserved)
   );

   fpsc_exc_bank #(.W(EXC_W), .STICKY(1'b0)) u_cause (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (op_start),
      .set_vec (exc_vec),
      .wr_en   (wr_en),
      .wr_val  (wr_data[CAUSE_LSB +: EXC_W]),
      .q       (cause_q)
   );

   fpsc_exc_bank #(.W(EXC_W), .STICKY(1'b1)) u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (op_start),
      .set_vec (exc_vec),
      .wr_en   (wr_en),
      .wr_val  (wr_data[FLAG_LSB +: EXC_W]),
      .q       (flag_q)
   );

   always_comb begin
      rd_data                       = '0;
      rd_data[RM_W-1:0]             = rm_raw;
      rd_data[CAUSE_LSB +: EXC_W]   = cause_q;
      rd_data[FLAG_LSB +: EXC_W]    = flag_q;
   end

   // ---------------- assertions ----------------
   p_cause_refill_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (op_start && !wr_en) |=> (rd_data[CAUSE_LSB +: EXC_W] == $past(exc_vec)));

   p_exc_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ((flag_q & $past(exc_vec)) == $past(exc_vec)));

   p_flag_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

   p_rm_fallback_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rm_reserved |-> (rm_out == RM_NEAREST && rm_raw[1]));

   p_write_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (rd_data[USED_W-1:0] == $past(wr_data[USED_W-1:0])));

   p_rsv_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (rd_data[DATA_W-1:USED_W] == '0));

endmodule

// File: tb/fpsc_reg_bench.sv
module fpsc_reg_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_start = 1'b0;
   logic [4:0]  exc_vec = '0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic [1:0]  rm_out;
   logic        rm_reserved;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   // reference model state
   int m_rm    = 0;
   int m_cause = 0;
   int m_flag  = 0;

   always #10 clk = ~clk;  // 50 MHz

   fpsc_reg u_fpsc_reg (
      .clk(clk), .rst_n(rst_n), .op_start(op_start), .exc_vec(exc_vec),
      .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .rm_out(rm_out), .rm_reserved(rm_reserved)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // compare every output field against the model
   task automatic compare_all();
      int exp_out;
      chk("R5 R7 rm field", int'(rd_data[1:0]), m_rm);
      chk("R2 R3 R8 cause field", int'(rd_data[6:2]), m_cause);
      chk("R3 R4 R8 flag field", int'(rd_data[11:7]), m_flag);
      chk("R6 reserved bits", int'(rd_data[31:12]), 0);
      exp_out = (m_rm > 1) ? 0 : m_rm;
      chk("R5 R7 rm_out", int'(rm_out), exp_out);
      chk("R7 rm_reserved", int'(rm_reserved), (m_rm > 1) ? 1 : 0);
   endtask

   // compare, drive one cycle of stimulus, advance the model
   task automatic step(input bit op, input int exc, input bit we, input int wd);
      @(negedge clk);
      compare_all();
      op_start = op;
      exc_vec  = exc[4:0];
      wr_en    = we;
      wr_data  = wd;
      if (we) begin
         m_rm    = wd & 3;
         m_cause = (wd >> 2) & 31;
         m_flag  = (wd >> 7) & 31;
      end else begin
         m_cause = op ? (exc & 31) : (m_cause | (exc & 31));
         m_flag  = m_flag | (exc & 31);
      end
   endtask

   initial begin
      #4_000_000;
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 reset rd_data", int'(rd_data), 0);
      chk("R1 reset rm_out", int'(rm_out), 0);
      chk("R1 reset rm_reserved", int'(rm_reserved), 0);
      rst_n = 1'b1;

      // R3: reports accumulate in cause and flag
      step(0, 5'b00001, 0, 0);
      step(0, 5'b00100, 0, 0);
      step(0, 0, 0, 0);
      // R2: op start wipes cause, R4: flags stay
      step(1, 0, 0, 0);
      step(0, 5'b10000, 0, 0);
      // R2: op start together with a report
      step(1, 5'b01000, 0, 0);
      step(1, 5'b00010, 0, 0);
      step(0, 0, 0, 0);
      // R8: write clears flags and loads cause
      step(0, 0, 1, 32'h0000_0054);
      step(0, 0, 0, 0);
      // R8: write collides with op start and a report
      step(1, 5'b11111, 1, 32'h0000_0F81);
      step(0, 0, 0, 0);
      // R5 and R7: every rounding code
      for (int c = 0; c < 4; c++) begin
         step(0, 0, 1, c);
         step(0, 0, 0, 0);
      end
      // R6: writes of all ones leave reserved bits zero
      step(0, 0, 1, 32'hFFFF_FFFF);
      step(0, 0, 0, 0);
      step(0, 0, 1, 32'hFFC0_0000);
      step(0, 0, 0, 0);
      // mixed traffic
      for (int k = 0; k < 2000; k++) begin
         int r;
         r = $urandom;
         step(r[0] & r[1], (r[2] ? (r >> 8) : 0), (r[5:3] == 3'b000), $urandom);
      end
      step(0, 0, 0, 0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule